// File: doc/BRIEF.md
# Translation Enable Command Controller

This block switches address translation on or off in a DMA remapping unit. Software asks for a new mode through a 32-bit command register. It learns that the switch has finished through a separate, read-only status register. The request does not take effect at once. The controller first stalls new translated requests, then waits for the count of translated requests still in flight to reach zero. After that it waits for a transaction boundary and only then flips the remap-active output. This output steers the translation datapath.

Each transaction is therefore handled wholly with remapping or wholly without it. The status bit follows the new mode one cycle after the flip. A write that asks for the mode already in force does nothing. A write that arrives while a switch is in progress is held and applied once the current switch has finished.

Top module: `xlate_enable_ctrl`

## Requirements
- R1: After reset, remap_active is 0, req_stall is 0, and both registers read as all zeros.
- R2: A write with bit 31 = 1 to offset 0x18, made while translation is off, sets remap_active. With the in-flight count at zero and the boundary input high, remap_active rises on the second clock edge after the write edge.
- R3: remap_active never changes on the edge after a cycle in which inflight_cnt was nonzero. A pending switch waits until the count is zero.
- R4: remap_active changes only on an edge where txn_boundary is high. A pending switch waits while txn_boundary stays low.
- R5: The status register at offset 0x1C shows the current mode in bit 31. This bit takes the new remap_active value one cycle after the mode flips. Bits 30..0 always read 0.
- R6: A command write that asks for the mode already in effect completes at once. It raises no stall and leaves remap_active and the status bit unchanged.
- R7: A command write made while a switch is pending is held. If several arrive, the latest one is kept. It is acted on after the current switch has completed.
- R8: Only bit 31 of a command write is acted on. Writes to any address other than 0x18, including the status offset, have no effect.
- R9: Reads of the command register return 0 in every bit.
- R10: req_stall is high from the cycle after a mode-changing request is accepted until the mode flips, and low whenever no switch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset used for both reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| txn_boundary | input | 1 | High when the request path sits between transactions |
| inflight_cnt | input | CNT_W | Number of translated requests still queued |
| remap_active | output | 1 | Translation mode applied to the datapath |
| req_stall | output | 1 | Backpressure for new translated requests during a switch |

## Verification
The hardest situation to reach from the ports is a second command that lands while a switch is still pending. That command must be parked, and it must not disturb the switch already under way. The stimulus gets there by holding inflight_cnt nonzero, which pins the controller in its drain wait. It then writes a request for the opposite mode and releases the count. The bench checks that the first switch completes in full, status included, before the held request starts its own drain and boundary sequence. Separate tests hold the count or the boundary input in place for several cycles, to show that neither condition alone lets the mode move.

// File: rtl/xlate_enable_ctrl.sv
module xlate_enable_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 6,
  parameter int EN_BIT = 31,
  parameter logic [ADDR_W-1:0] CMD_OFS = 8'h18,
  parameter logic [ADDR_W-1:0] STS_OFS = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              txn_boundary,
  input  logic [CNT_W-1:0]  inflight_cnt,
  output logic              remap_active,
  output logic              req_stall
);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_BOUND, S_COMMIT} state_t;

  state_t state;
  logic remap_q, sts_q, tgt_q, hold_vld, hold_val;
  logic req_vld, req_val;

  logic wr_cmd, wr_en_val, start, unused_wdata;
  assign wr_cmd = reg_wr && (reg_addr == CMD_OFS);
  assign wr_en_val = reg_wdata[EN_BIT];
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    if (hold_vld) begin
      req_vld = 1'b1;
      req_val = hold_val;
    end else begin
      req_vld = wr_cmd;
      req_val = wr_en_val;
    end
  end

  assign start = (state == S_IDLE) && req_vld && (req_val != remap_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      remap_q  <= 1'b0;
      sts_q    <= 1'b0;
      tgt_q    <= 1'b0;
      hold_vld <= 1'b0;
      hold_val <= 1'b0;
    end else begin
      if (state != S_IDLE) begin
        if (wr_cmd) begin
          hold_vld <= 1'b1;
          hold_val <= wr_en_val;
        end
      end else if (hold_vld) begin
        hold_vld <= wr_cmd;
        hold_val <= wr_en_val;
      end
      case (state)
        S_IDLE: if (start) begin
          tgt_q <= req_val;
          state <= S_DRAIN;
        end
        S_DRAIN: if (inflight_cnt == '0) state <= S_BOUND;
        S_BOUND: if (txn_boundary) begin
          remap_q <= tgt_q;
          state   <= S_COMMIT;
        end
        default: begin
          sts_q <= remap_q;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign remap_active = remap_q;
  assign req_stall = (state == S_DRAIN) || (state == S_BOUND);
  assign reg_rdata = (reg_addr == STS_OFS) ? (DATA_W'(sts_q) << EN_BIT) : '0;

  assert_no_switch_inflight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inflight_cnt) != '0) |-> (remap_q == $past(remap_q)));

  assert_switch_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_q != $past(remap_q)) |-> $past(txn_boundary));

  assert_status_tracks_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q != $past(sts_q)) |-> (sts_q == $past(remap_q)));

  assert_same_mode_no_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !hold_vld && wr_cmd && wr_en_val == remap_q) |=> (state == S_IDLE));

  assert_switch_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_q != $past(remap_q)) |-> $past(req_stall));

endmodule

// File: tb/test_xlate_enable_ctrl.sv
module test_xlate_enable_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic txn_boundary = 1'b1;
  logic [5:0] inflight_cnt = '0;
  logic remap_active, req_stall;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [7:0] CMD = 8'h18;
  localparam logic [7:0] STS = 8'h1C;

  always #10 clk = ~clk;

  xlate_enable_ctrl i_xlate_enable_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_boundary(txn_boundary),
    .inflight_cnt(inflight_cnt), .remap_active(remap_active), .req_stall(req_stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 8'h00;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 remap after reset", 32'(remap_active), 0);
    chk("R1 stall after reset", 32'(req_stall), 0);
    rd(STS, d); chk("R1 status after reset", d, 0);
    rd(CMD, d); chk("R9 command reads zero", d, 0);
  endtask

  task automatic t_enable_fast;
    logic [31:0] d;
    wr(CMD, 32'h8000_0000);
    chk("R10 stall after accept", 32'(req_stall), 1);
    chk("R2 remap not yet", 32'(remap_active), 0);
    cyc(1);
    chk("R2 remap before boundary edge", 32'(remap_active), 0);
    cyc(1);
    chk("R2 remap set", 32'(remap_active), 1);
    chk("R10 stall drops after flip", 32'(req_stall), 0);
    rd(STS, d); chk("R5 status lags one cycle", d, 0);
    cyc(1);
    rd(STS, d); chk("R5 status set", d, 32'h8000_0000);
    rd(CMD, d); chk("R9 command reads zero when enabled", d, 0);
  endtask

  task automatic t_drain;
    logic [31:0] d;
    inflight_cnt = 6'd5;
    wr(CMD, 32'h0000_0000);
    cyc(6);
    chk("R3 mode held while draining", 32'(remap_active), 1);
    chk("R10 stall held while draining", 32'(req_stall), 1);
    inflight_cnt = 6'd0;
    cyc(1);
    chk("R3 mode held one edge after drain", 32'(remap_active), 1);
    cyc(1);
    chk("R3 mode cleared after drain", 32'(remap_active), 0);
    cyc(1);
    rd(STS, d); chk("R5 status cleared", d, 0);
  endtask

  task automatic t_boundary;
    logic [31:0] d;
    txn_boundary = 1'b0;
    wr(CMD, 32'h8000_0000);
    cyc(5);
    chk("R4 no switch without boundary", 32'(remap_active), 0);
    chk("R10 stall in boundary wait", 32'(req_stall), 1);
    txn_boundary = 1'b1;
    cyc(1);
    chk("R4 switch at boundary", 32'(remap_active), 1);
    cyc(1);
    rd(STS, d); chk("R5 status after boundary switch", d, 32'h8000_0000);
  endtask

  task automatic t_same_mode;
    logic [31:0] d;
    wr(CMD, 32'h8000_0000);
    chk("R6 no stall for same mode", 32'(req_stall), 0);
    cyc(3);
    chk("R6 mode unchanged", 32'(remap_active), 1);
    rd(STS, d); chk("R6 status unchanged", d, 32'h8000_0000);
  endtask

  task automatic t_other_bits;
    wr(CMD, 32'hFFFF_FFFF);
    chk("R8 extra bits raise no stall", 32'(req_stall), 0);
    cyc(3);
    chk("R8 extra bits ignored", 32'(remap_active), 1);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    inflight_cnt = 6'd3;
    wr(CMD, 32'h0000_0000);
    wr(CMD, 32'h8000_0000);
    chk("R7 first switch still pending", 32'(remap_active), 1);
    inflight_cnt = 6'd0;
    cyc(3);
    chk("R7 first switch done", 32'(remap_active), 0);
    rd(STS, d); chk("R7 first switch status", d, 0);
    cyc(1);
    chk("R7 held request starts", 32'(req_stall), 1);
    cyc(3);
    chk("R7 held request applied", 32'(remap_active), 1);
    rd(STS, d); chk("R7 held request status", d, 32'h8000_0000);
  endtask

  task automatic t_wrong_addr;
    logic [31:0] d;
    wr(STS, 32'h0000_0000);
    wr(8'h20, 32'h0000_0000);
    wr(8'h19, 32'h0000_0000);
    chk("R8 other address raises no stall", 32'(req_stall), 0);
    cyc(4);
    chk("R8 other address ignored", 32'(remap_active), 1);
    rd(STS, d); chk("R8 status unchanged by writes", d, 32'h8000_0000);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_enable_fast();
    t_drain();
    t_boundary();
    t_same_mode();
    t_other_bits();
    t_hold();
    t_wrong_addr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule